// File: doc/BRIEF.md
# Rename Map Table with Branch Checkpoints

This block holds the speculative mapping from logical registers to physical registers in an out-of-order core's rename stage. Each cycle it looks up the physical registers currently bound to two logical sources and the mapping about to be replaced at the logical destination. It then installs the freshly allocated physical register at the destination index.

For branch recovery it keeps a small pool of shadow copies of the whole table. When a predicted branch is renamed, the table contents after that branch's own destination write are captured into a free copy, and the branch receives a one-hot tag bit. Every renamed instruction is handed the set of tag bits of the branches still unresolved ahead of it.

When a branch resolves correctly, only its copy is released and its bit disappears from the recorded masks. When a branch is found mispredicted, the table is reloaded from that branch's copy in a single cycle. Its copy is released, along with every copy belonging to a younger branch. An exception-recovery input replaces the table with the committed map supplied from outside and releases all copies.

Top module: `rename_ckpt_map`

## Requirements
- R1: After reset the table maps every logical register i to physical register i, no copy is live, ren_mask is zero and ren_stall is zero. The source and destination lookups are combinational reads of the current table.
- R2: An accepted rename with ren_dst_valid=1 writes ren_new_phys at index ren_dst, and reads see it from the next cycle. With ren_dst_valid=0 the table is not written.
- R3: An accepted branch rename captures the table including that branch's own destination write. The copy used is the lowest-index free one, and its one-hot bit (bit k means copy k) is shown on ren_ckpt_bit in the same cycle.
- R4: ren_mask presents the tag bits of all unresolved branches, after any resolution in the same cycle. For a branch being renamed, ren_mask does not include that branch's own bit.
- R5: A correct resolution (res_valid=1, res_mispredict=0, one-hot res_bit) releases only that branch's copy and leaves the table unchanged.
- R6: A misprediction reloads the table from the resolving branch's copy on the next cycle. It releases that copy and every copy whose recorded mask contains the resolving bit, while older copies stay live.
- R7: A rename presented in the same cycle as a misprediction or exception recovery is dropped: it makes no table write and takes no copy.
- R8: A branch rename with all four copies live is stalled: ren_stall=1 and neither the table nor the pool changes. A non-branch rename never stalls.
- R9: A correct resolution in the same cycle as a branch rename frees its copy first. The branch may take that copy, and its recorded mask excludes the resolved bit.
- R10: exc_restore=1 loads arch_map into the table on the next cycle and releases all copies. It takes priority over any resolution in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_is_branch | input | 1 | Renamed instruction is a predicted branch |
| ren_src1 | input | LW | First logical source |
| ren_src2 | input | LW | Second logical source |
| ren_dst | input | LW | Logical destination |
| ren_dst_valid | input | 1 | Instruction writes a destination |
| ren_new_phys | input | PW | Newly allocated physical destination |
| res_valid | input | 1 | A branch resolves this cycle |
| res_mispredict | input | 1 | The resolving branch was mispredicted |
| res_bit | input | NC | One-hot tag of the resolving branch |
| exc_restore | input | 1 | Load the committed map and drop all copies |
| arch_map | input | NL*PW | Committed map, entry i at bits i*PW +: PW |
| src1_phys | output | PW | Mapping of ren_src1 |
| src2_phys | output | PW | Mapping of ren_src2 |
| dst_prev_phys | output | PW | Mapping of ren_dst before this rename |
| ren_stall | output | 1 | Branch rename held for lack of a free copy |
| ren_mask | output | NC | Unresolved-branch mask for the renamed instruction |
| ren_ckpt_bit | output | NC | One-hot tag given to a branch being renamed |

## Verification
The bench builds the block with its defaults: 32 logical registers, 7-bit physical tags and four copies. With only four copies, a few directed branches fill the pool, so the stall and the same-cycle free-and-reuse case come up quickly. The 7-bit tags leave room for a committed map whose values are clearly distinct from the identity reset map. The directed scenarios nest up to four branches, so both releasing the younger set and keeping an older copy live can be observed through ren_mask and the table reads.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    localparam int unsigned LOG_REGS_DEF = 32;
    localparam int unsigned PHYS_W_DEF   = 7;
    localparam int unsigned CKPT_DEF     = 4;

    // Pool action decided from the recovery inputs, highest priority first
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_KEEP   = 2'd1,
        ACT_SQUASH = 2'd2,
        ACT_FLUSH  = 2'd3
    } pool_act_e;

    function automatic pool_act_e decode_act(input logic flush,
                                             input logic res_v,
                                             input logic misp);
        if (flush)
            return ACT_FLUSH;
        else if (res_v && misp)
            return ACT_SQUASH;
        else if (res_v)
            return ACT_KEEP;
        return ACT_NONE;
    endfunction

endpackage

// File: rtl/rmc_map_table.sv
module rmc_map_table #(
    parameter int unsigned NL = rmc_pkg::LOG_REGS_DEF,
    parameter int unsigned PW = rmc_pkg::PHYS_W_DEF,
    localparam int unsigned LW = $clog2(NL)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LW-1:0]          rd_a,
    input  logic [LW-1:0]          rd_b,
    input  logic [LW-1:0]          rd_d,
    input  logic                   wr_en,
    input  logic [LW-1:0]          wr_idx,
    input  logic [PW-1:0]          wr_data,
    input  logic                   restore_en,
    input  logic [NL-1:0][PW-1:0]  restore_data,
    output logic [PW-1:0]          rd_a_data,
    output logic [PW-1:0]          rd_b_data,
    output logic [PW-1:0]          rd_d_data,
    output logic [NL-1:0][PW-1:0]  next_map
);

    logic [NL-1:0][PW-1:0] map_q;

    assign rd_a_data = map_q[rd_a];
    assign rd_b_data = map_q[rd_b];
    assign rd_d_data = map_q[rd_d];

    // Table contents with this cycle's destination write applied
    always_comb begin
        next_map = map_q;
        if (wr_en)
            next_map[wr_idx] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NL); i++)
                map_q[i] <= PW'(i);
        end else if (restore_en) begin
            map_q <= restore_data;
        end else begin
            map_q <= next_map;
        end
    end

    assert_restore_loads_R6: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (map_q == $past(restore_data)));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !restore_en) |=> (map_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/rmc_ckpt_pool.sv
module rmc_ckpt_pool
    import rmc_pkg::*;
#(
    parameter int unsigned NL = rmc_pkg::LOG_REGS_DEF,
    parameter int unsigned PW = rmc_pkg::PHYS_W_DEF,
    parameter int unsigned NC = rmc_pkg::CKPT_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  pool_act_e              act,
    input  logic [NC-1:0]          res_bit,
    input  logic                   take,
    input  logic [NL-1:0][PW-1:0]  snap,
    output logic                   has_free,
    output logic [NC-1:0]          alloc_bit,
    output logic [NC-1:0]          live_eff,
    output logic [NL-1:0][PW-1:0]  restore_map
);

    logic [NC-1:0]         live_q;
    logic [NC-1:0]         mask_w   [NC];
    logic [NL-1:0][PW-1:0] shadow_w [NC];
    logic [NC-1:0]         younger;
    logic [NC-1:0]         reclaim;
    logic [NC-1:0]         free_v;

    // A copy is younger than the resolving branch when its recorded mask holds that bit
    always_comb begin
        for (int k = 0; k < int'(NC); k++)
            younger[k] = |(mask_w[k] & res_bit);
    end

    always_comb begin
        unique case (act)
            ACT_KEEP:   reclaim = res_bit;
            ACT_SQUASH: reclaim = res_bit | younger;
            ACT_FLUSH:  reclaim = '1;
            default:    reclaim = '0;
        endcase
    end

    assign live_eff = live_q & ~reclaim;
    assign free_v   = ~live_eff;
    assign has_free = |free_v;

    // Lowest-index free copy
    always_comb begin
        alloc_bit = '0;
        for (int k = 0; k < int'(NC); k++)
            if (free_v[k] && (alloc_bit == '0))
                alloc_bit[k] = 1'b1;
    end

    // One-hot selection of the resolving branch's copy
    always_comb begin
        restore_map = '0;
        for (int k = 0; k < int'(NC); k++)
            if (res_bit[k])
                restore_map = restore_map | shadow_w[k];
    end

    always_ff @(posedge clk) begin
        if (rst)
            live_q <= '0;
        else
            live_q <= live_eff | (take ? alloc_bit : '0);
    end

    for (genvar g = 0; g < int'(NC); g++) begin : g_copy
        logic [NC-1:0]         m_q;
        logic [NL-1:0][PW-1:0] s_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= '0;
                s_q <= '0;
            end else if (take && alloc_bit[g]) begin
                m_q <= live_eff;
                s_q <= snap;
            end else begin
                m_q <= m_q & ~reclaim;
            end
        end

        assign mask_w[g]   = m_q;
        assign shadow_w[g] = s_q;

        assert_own_bit_clear_R4: assert property (@(posedge clk) disable iff (rst)
            !m_q[g]);
    end

    assert_squash_frees_R6: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SQUASH) |=> ((live_q & $past(res_bit)) == '0));

    assert_take_marks_live_R3: assert property (@(posedge clk) disable iff (rst)
        take |=> ((live_q & $past(alloc_bit)) != '0));

    assert_keep_only_one_R5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_KEEP && !take) |=> (live_q == ($past(live_q) & ~$past(res_bit))));

    assert_alloc_free_R8: assert property (@(posedge clk) disable iff (rst)
        take |-> ($onehot0(alloc_bit) && ((alloc_bit & live_eff) == '0)));

endmodule

// File: rtl/rename_ckpt_map.sv
module rename_ckpt_map
    import rmc_pkg::*;
#(
    parameter int unsigned NL = rmc_pkg::LOG_REGS_DEF,
    parameter int unsigned PW = rmc_pkg::PHYS_W_DEF,
    parameter int unsigned NC = rmc_pkg::CKPT_DEF,
    localparam int unsigned LW = $clog2(NL)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ren_valid,
    input  logic                   ren_is_branch,
    input  logic [LW-1:0]          ren_src1,
    input  logic [LW-1:0]          ren_src2,
    input  logic [LW-1:0]          ren_dst,
    input  logic                   ren_dst_valid,
    input  logic [PW-1:0]          ren_new_phys,
    input  logic                   res_valid,
    input  logic                   res_mispredict,
    input  logic [NC-1:0]          res_bit,
    input  logic                   exc_restore,
    input  logic [NL-1:0][PW-1:0]  arch_map,
    output logic [PW-1:0]          src1_phys,
    output logic [PW-1:0]          src2_phys,
    output logic [PW-1:0]          dst_prev_phys,
    output logic                   ren_stall,
    output logic [NC-1:0]          ren_mask,
    output logic [NC-1:0]          ren_ckpt_bit
);

    pool_act_e             act;
    logic                  has_free;
    logic [NC-1:0]         alloc_bit;
    logic [NC-1:0]         live_eff;
    logic [NL-1:0][PW-1:0] ckpt_map;
    logic [NL-1:0][PW-1:0] next_map;
    logic [NL-1:0][PW-1:0] restore_src;
    logic                  recover;
    logic                  ren_go;
    logic                  take;

    assign act     = decode_act(exc_restore, res_valid, res_mispredict);
    assign recover = (act == ACT_SQUASH) || (act == ACT_FLUSH);

    assign ren_stall = ren_valid && ren_is_branch && !has_free;
    assign ren_go    = ren_valid && !ren_stall && !recover;
    assign take      = ren_go && ren_is_branch;

    assign restore_src  = (act == ACT_FLUSH) ? arch_map : ckpt_map;
    assign ren_mask     = live_eff;
    assign ren_ckpt_bit = ren_is_branch ? alloc_bit : '0;

    rmc_map_table #(.NL(NL), .PW(PW)) u_table (
        .clk          (clk),
        .rst          (rst),
        .rd_a         (ren_src1),
        .rd_b         (ren_src2),
        .rd_d         (ren_dst),
        .wr_en        (ren_go && ren_dst_valid),
        .wr_idx       (ren_dst),
        .wr_data      (ren_new_phys),
        .restore_en   (recover),
        .restore_data (restore_src),
        .rd_a_data    (src1_phys),
        .rd_b_data    (src2_phys),
        .rd_d_data    (dst_prev_phys),
        .next_map     (next_map)
    );

    rmc_ckpt_pool #(.NL(NL), .PW(PW), .NC(NC)) u_pool (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .res_bit     (res_bit),
        .take        (take),
        .snap        (next_map),
        .has_free    (has_free),
        .alloc_bit   (alloc_bit),
        .live_eff    (live_eff),
        .restore_map (ckpt_map)
    );

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
        exc_restore |=> (ren_mask == '0));

    assert_drop_on_recover_R7: assert property (@(posedge clk) disable iff (rst)
        (exc_restore && ren_valid && !ren_is_branch) |=> (ren_mask == '0));

endmodule

// File: tb/rename_ckpt_map_tb.sv
module rename_ckpt_map_tb;

    localparam int NL = 32;
    localparam int PW = 7;
    localparam int NC = 4;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  ren_valid, ren_is_branch, ren_dst_valid;
    logic [4:0]            ren_src1, ren_src2, ren_dst;
    logic [PW-1:0]         ren_new_phys;
    logic                  res_valid, res_mispredict, exc_restore;
    logic [NC-1:0]         res_bit;
    logic [NL-1:0][PW-1:0] arch_map;
    logic [PW-1:0]         src1_phys, src2_phys, dst_prev_phys;
    logic                  ren_stall;
    logic [NC-1:0]         ren_mask, ren_ckpt_bit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rename_ckpt_map u_dut (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_is_branch(ren_is_branch),
        .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_dst(ren_dst),
        .ren_dst_valid(ren_dst_valid), .ren_new_phys(ren_new_phys),
        .res_valid(res_valid), .res_mispredict(res_mispredict), .res_bit(res_bit),
        .exc_restore(exc_restore), .arch_map(arch_map),
        .src1_phys(src1_phys), .src2_phys(src2_phys), .dst_prev_phys(dst_prev_phys),
        .ren_stall(ren_stall), .ren_mask(ren_mask), .ren_ckpt_bit(ren_ckpt_bit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drv_idle();
        ren_valid = 0; ren_is_branch = 0; ren_dst_valid = 0;
        ren_src1 = 0; ren_src2 = 0; ren_dst = 0; ren_new_phys = 0;
        res_valid = 0; res_mispredict = 0; res_bit = 0; exc_restore = 0;
    endtask

    task automatic drv_ren(input logic br, input int d, input int np);
        ren_valid = 1; ren_is_branch = br; ren_dst_valid = 1;
        ren_dst = 5'(d); ren_new_phys = PW'(np);
    endtask

    task automatic drv_res(input logic misp, input logic [NC-1:0] b);
        res_valid = 1; res_mispredict = misp; res_bit = b;
    endtask

    task automatic rd(input int a, input int b, input int d);
        ren_src1 = 5'(a); ren_src2 = 5'(b); ren_dst = 5'(d);
    endtask

    // commit the current cycle and move to the middle of the next one
    task automatic nxt();
        @(posedge clk); #1; drv_idle(); #1;
    endtask

    task automatic t_reset();
        rd(5, 31, 0); #1;
        chk("R1 src1 identity", 32'(src1_phys), 5);
        chk("R1 src2 identity", 32'(src2_phys), 31);
        chk("R1 dst identity", 32'(dst_prev_phys), 0);
        chk("R1 mask empty", 32'(ren_mask), 0);
        chk("R1 no stall", 32'(ren_stall), 0);
    endtask

    task automatic t_write();
        drv_ren(0, 3, 40); #1;
        chk("R2 prev mapping", 32'(dst_prev_phys), 3);
        nxt();
        rd(3, 4, 0); #1;
        chk("R2 write visible", 32'(src1_phys), 40);
        drv_ren(0, 4, 50); ren_dst_valid = 0; nxt();
        rd(3, 4, 0); #1;
        chk("R2 no write without dst", 32'(src2_phys), 4);
    endtask

    task automatic t_branch();
        drv_ren(1, 6, 60); #1;
        chk("R3 first copy bit", 32'(ren_ckpt_bit), 1);
        chk("R4 branch mask excludes self", 32'(ren_mask), 0);
        nxt();
        drv_ren(0, 6, 61); nxt();
        drv_ren(0, 7, 70); #1;
        chk("R4 younger inherits bit", 32'(ren_mask), 1);
        nxt();
        drv_res(1, 4'b0001); nxt();
        rd(6, 7, 3); #1;
        chk("R3 copy holds branch write", 32'(src1_phys), 60);
        chk("R6 younger write undone", 32'(src2_phys), 7);
        chk("R6 older write kept", 32'(dst_prev_phys), 40);
        chk("R6 copy released", 32'(ren_mask), 0);
    endtask

    task automatic t_nested();
        drv_ren(1, 1, 81); nxt();
        drv_ren(1, 2, 82); #1;
        chk("R4 second branch mask", 32'(ren_mask), 4'b0001);
        chk("R3 second copy bit", 32'(ren_ckpt_bit), 4'b0010);
        nxt();
        drv_ren(1, 5, 85); #1;
        chk("R4 third branch mask", 32'(ren_mask), 4'b0011);
        nxt();
        drv_res(0, 4'b0010); nxt();
        rd(2, 0, 0); #1;
        chk("R5 only one copy freed", 32'(ren_mask), 4'b0101);
        chk("R5 table untouched", 32'(src1_phys), 82);
        drv_ren(0, 1, 91); nxt();
        drv_ren(1, 8, 88); #1;
        chk("R3 reuse lowest free copy", 32'(ren_ckpt_bit), 4'b0010);
        chk("R5 resolved bit gone from mask", 32'(ren_mask), 4'b0101);
        nxt();
        drv_res(1, 4'b0100); nxt();
        rd(1, 5, 8); #1;
        chk("R6 older copy stays live", 32'(ren_mask), 4'b0001);
        chk("R6 restore src1", 32'(src1_phys), 81);
        chk("R6 restore branch dst", 32'(src2_phys), 85);
        chk("R6 younger branch write undone", 32'(dst_prev_phys), 8);
        drv_res(0, 4'b0001); nxt();
        chk("R5 last copy freed", 32'(ren_mask), 0);
    endtask

    task automatic t_full();
        for (int i = 0; i < NC; i++) begin
            drv_ren(1, 10 + i, 20 + i); #1;
            chk("R3 sequential copy bit", 32'(ren_ckpt_bit), 32'(1 << i));
            nxt();
        end
        chk("R8 pool full", 32'(ren_mask), 4'b1111);
        drv_ren(1, 14, 30); #1;
        chk("R8 branch stalls", 32'(ren_stall), 1);
        nxt();
        rd(14, 0, 0); #1;
        chk("R8 stalled write absent", 32'(src1_phys), 14);
        chk("R8 pool unchanged", 32'(ren_mask), 4'b1111);
        drv_ren(0, 15, 31); #1;
        chk("R8 non-branch not stalled", 32'(ren_stall), 0);
        nxt();
        // correct resolve and branch rename together
        drv_res(0, 4'b0100); drv_ren(1, 16, 32); #1;
        chk("R9 no stall after same-cycle free", 32'(ren_stall), 0);
        chk("R9 reuses freed copy", 32'(ren_ckpt_bit), 4'b0100);
        chk("R9 mask excludes resolved", 32'(ren_mask), 4'b1011);
        nxt();
        chk("R9 pool full again", 32'(ren_mask), 4'b1111);
        // mispredict oldest, with a rename in the same cycle
        drv_res(1, 4'b0001); drv_ren(0, 9, 99); nxt();
        rd(9, 15, 16); #1;
        chk("R7 dropped rename", 32'(src1_phys), 9);
        chk("R6 all younger released", 32'(ren_mask), 0);
        chk("R6 restore drops later write", 32'(src2_phys), 15);
        chk("R6 restore drops branch write", 32'(dst_prev_phys), 16);
    endtask

    task automatic t_exc();
        for (int i = 0; i < NL; i++) arch_map[i] = PW'(i + 64);
        drv_ren(1, 3, 100); nxt();
        exc_restore = 1; drv_res(1, 4'b0001); drv_ren(0, 4, 101); nxt();
        rd(3, 4, 31); #1;
        chk("R10 committed map loaded", 32'(src1_phys), 67);
        chk("R7 rename during exception dropped", 32'(src2_phys), 68);
        chk("R10 committed map last entry", 32'(dst_prev_phys), 95);
        chk("R10 all copies released", 32'(ren_mask), 0);
    endtask

    initial begin
        drv_idle();
        for (int i = 0; i < NL; i++) arch_map[i] = '0;
        rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0; #1;
        t_reset();
        t_write();
        t_branch();
        t_nested();
        t_full();
        t_exc();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule